// File: doc/BRIEF.md
# Zone Resource Admission Controller

This block keeps three per-namespace resource counts for a zoned storage target: how many zones are active, how many are open, and how many zone random-write-area (RWA) slots are still free. Zone-management logic hands it one event per cycle. The event is an open, finish or reset of a single zone, and it comes with the zone's prior state and its current attribute byte. The block answers with a 16-bit status code. On success it also returns the updated attribute byte. The decision and the counter update both take effect on the clock edge that samples the request.

An open can ask for an RWA slot as well. That request has its own preconditions: the capability must be enabled and the write pointer must lie on a flush-granularity boundary. An RWA open is admitted only if all three pools have room. The pools are checked in a fixed priority order, and a rejected request leaves every count and the attribute byte untouched. Finishing or resetting an active zone returns its resources. The limits, the RWA slot count and the capability enable are static configuration inputs. A limit of zero removes that limit.

Top module: `zone_admit_ctrl`

## Requirements
- R1: After reset, `rsp_valid` is 0, `active_cnt` and `open_cnt` are 0, and `rwa_free` equals `cfg_rwa_slots`, or `NUM_ZONES` when `cfg_rwa_slots` is 0.
- R2: A request sampled at a rising edge with `req_valid`=1 gives `rsp_valid`=1 and its status after that edge, and the counters are updated at the same edge. Operation codes: 1 open, 2 finish, 3 reset. Zone state codes: 0 empty, 1 implicitly open, 2 explicitly open, 3 closed, 4 read-only, 5 full, 6 offline. An open from empty adds one active and one open zone. An open from closed adds one open zone. An open from either open state changes no count. Success is status 0.
- R3: A `cfg_max_active` or `cfg_max_open` of 0 disables that limit.
- R4: Every failure status has bit 14 (do-not-retry) set. Resource checks run in this order: active limit exceeded (0x41BD), then open limit exceeded (0x41BE), then no free RWA slot when one is requested (0x41B7). A failed request changes no counter and returns `rsp_attr` equal to `req_attr`.
- R5: An open requesting an RWA while `cfg_rwa_en`=0 fails with 0x41B6, ahead of every other check.
- R6: An open requesting an RWA with `req_wp_aligned`=0 fails with 0x41B7, ahead of the resource checks.
- R7: A granted RWA open decrements `rwa_free` and sets bit 3 (RWA-valid) of `rsp_attr`.
- R8: A finish or reset from an open state decrements both `active_cnt` and `open_cnt`. From closed it decrements `active_cnt` only. From empty or full it is a successful no-op on the counts.
- R9: A finish or reset from an open or closed state of a zone whose `req_attr` bit 3 is set returns one slot to `rwa_free`. A finish clears bit 3 in `rsp_attr`. A reset passes the attribute through unchanged.
- R10: An open from read-only, full or offline, or a finish or reset from read-only or offline, fails with 0x41BF. An RWA open of a zone whose bit 3 is already set fails with 0x41B6. Operation code 0 fails with 0x4002.
- R11: The counters saturate. A release never takes a count below 0, and `rwa_free` never rises above its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_active | input | CW | Maximum active zones, 0 = unlimited |
| cfg_max_open | input | CW | Maximum open zones, 0 = unlimited |
| cfg_rwa_slots | input | CW | RWA slot count, 0 = one per zone |
| cfg_rwa_en | input | 1 | RWA capability enable |
| req_valid | input | 1 | Event strobe |
| req_op | input | 2 | Operation code |
| req_state | input | 3 | Prior zone state |
| req_attr | input | 8 | Zone attribute byte before the event |
| req_rwa | input | 1 | Open asks for an RWA slot |
| req_wp_aligned | input | 1 | Write pointer on flush-granularity boundary |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 16 | Status, 0 on success |
| rsp_attr | output | 8 | Zone attribute byte after the event |
| active_cnt | output | CW | Active zone count |
| open_cnt | output | CW | Open zone count |
| rwa_free | output | CW | Free RWA slots |

## Verification
Two functions can act on one request: the open/active admission and the RWA allocation. An RWA open of an empty zone claims all three pools in a single edge. The bench drives the active and open limits to their edge, then requests an RWA for an already-open zone while the RWA pool is empty. That request passes the active and open checks and then fails on the RWA check. The bench judges it by the 0x41B7 code and by all three counts reading unchanged afterwards. A release of an RWA-holding open zone likewise moves three counts in the same cycle, and the bench checks each of them.

// File: rtl/zra_pkg.sv
package zra_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_OPEN   = 2'd1,
    OP_FINISH = 2'd2,
    OP_RESET  = 2'd3
  } zra_op_e;

  typedef enum logic [2:0] {
    ZS_EMPTY    = 3'd0,
    ZS_IMP_OPEN = 3'd1,
    ZS_EXP_OPEN = 3'd2,
    ZS_CLOSED   = 3'd3,
    ZS_RDONLY   = 3'd4,
    ZS_FULL     = 3'd5,
    ZS_OFFLINE  = 3'd6
  } zra_state_e;

  localparam logic [15:0] ST_OK          = 16'h0000;
  localparam logic [15:0] ST_DNR         = 16'h4000;
  localparam logic [15:0] ST_BAD_FIELD   = 16'h0002;
  localparam logic [15:0] ST_BAD_ZONE_OP = 16'h01B6;
  localparam logic [15:0] ST_NO_RWA      = 16'h01B7;
  localparam logic [15:0] ST_MANY_ACTIVE = 16'h01BD;
  localparam logic [15:0] ST_MANY_OPEN   = 16'h01BE;
  localparam logic [15:0] ST_BAD_TRANS   = 16'h01BF;

  localparam int RWA_BIT = 3;

  function automatic logic [15:0] fail_code(input logic [15:0] code);
    return code | ST_DNR;
  endfunction

  function automatic logic is_open_state(input logic [2:0] s);
    return (s == ZS_IMP_OPEN) || (s == ZS_EXP_OPEN);
  endfunction

endpackage

// File: rtl/zra_admit.sv
module zra_admit
  import zra_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0] active_cnt,
  input  logic [CW-1:0] open_cnt,
  input  logic [CW-1:0] rwa_free,
  input  logic [CW-1:0] cfg_max_active,
  input  logic [CW-1:0] cfg_max_open,
  input  logic          cfg_rwa_en,
  input  logic [2:0]    state,
  input  logic [7:0]    attr_in,
  input  logic          want_rwa,
  input  logic          wp_aligned,
  output logic [15:0]   status,
  output logic          inc_active,
  output logic          inc_open,
  output logic          take_rwa,
  output logic [7:0]    attr_out
);

  logic          need_act;
  logic          need_open;
  logic          legal;
  logic [CW:0]   act_sum;
  logic [CW:0]   open_sum;
  logic          act_over;
  logic          open_over;
  logic          rwa_empty;

  always_comb begin
    need_act  = (state == ZS_EMPTY);
    need_open = (state == ZS_EMPTY) || (state == ZS_CLOSED);
    legal     = need_open || is_open_state(state);
    act_sum   = {1'b0, active_cnt} + {{CW{1'b0}}, need_act};
    open_sum  = {1'b0, open_cnt} + {{CW{1'b0}}, need_open};
    act_over  = (cfg_max_active != '0) && (act_sum > {1'b0, cfg_max_active});
    open_over = (cfg_max_open != '0) && (open_sum > {1'b0, cfg_max_open});
    rwa_empty = want_rwa && (rwa_free == '0);
  end

  always_comb begin
    status     = ST_OK;
    inc_active = 1'b0;
    inc_open   = 1'b0;
    take_rwa   = 1'b0;
    attr_out   = attr_in;
    if (want_rwa && !cfg_rwa_en) begin
      status = fail_code(ST_BAD_ZONE_OP);
    end else if (!legal) begin
      status = fail_code(ST_BAD_TRANS);
    end else if (want_rwa && attr_in[RWA_BIT]) begin
      status = fail_code(ST_BAD_ZONE_OP);
    end else if (want_rwa && !wp_aligned) begin
      status = fail_code(ST_NO_RWA);
    end else if (act_over) begin
      status = fail_code(ST_MANY_ACTIVE);
    end else if (open_over) begin
      status = fail_code(ST_MANY_OPEN);
    end else if (rwa_empty) begin
      status = fail_code(ST_NO_RWA);
    end else begin
      inc_active = need_act;
      inc_open   = need_open;
      take_rwa   = want_rwa;
      if (want_rwa) begin
        attr_out[RWA_BIT] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/zra_release.sv
module zra_release
  import zra_pkg::*;
(
  input  logic [2:0]  state,
  input  logic [7:0]  attr_in,
  input  logic        is_finish,
  output logic [15:0] status,
  output logic        dec_active,
  output logic        dec_open,
  output logic        give_rwa,
  output logic [7:0]  attr_out
);

  logic holds_active;
  logic quiet;

  always_comb begin
    holds_active = is_open_state(state) || (state == ZS_CLOSED);
    quiet        = (state == ZS_EMPTY) || (state == ZS_FULL);
  end

  always_comb begin
    status     = ST_OK;
    dec_active = 1'b0;
    dec_open   = 1'b0;
    give_rwa   = 1'b0;
    attr_out   = attr_in;
    if (holds_active) begin
      dec_active = 1'b1;
      dec_open   = is_open_state(state);
      give_rwa   = attr_in[RWA_BIT];
      if (is_finish) begin
        attr_out[RWA_BIT] = 1'b0;
      end
    end else if (!quiet) begin
      status = fail_code(ST_BAD_TRANS);
    end
  end

endmodule

// File: rtl/zra_counter.sv
module zra_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] max_val,
  input  logic          up,
  input  logic          dn,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_nxt = cnt;
    cnt_en  = 1'b0;
    if (up && !dn && (cnt < max_val)) begin
      cnt_nxt = cnt + 1'b1;
      cnt_en  = 1'b1;
    end else if (dn && !up && (cnt != '0)) begin
      cnt_nxt = cnt - 1'b1;
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= init_val;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/zone_admit_ctrl.sv
module zone_admit_ctrl
  import zra_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  parameter int CW        = $clog2(NUM_ZONES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_max_active,
  input  logic [CW-1:0] cfg_max_open,
  input  logic [CW-1:0] cfg_rwa_slots,
  input  logic          cfg_rwa_en,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [2:0]    req_state,
  input  logic [7:0]    req_attr,
  input  logic          req_rwa,
  input  logic          req_wp_aligned,
  output logic          rsp_valid,
  output logic [15:0]   rsp_status,
  output logic [7:0]    rsp_attr,
  output logic [CW-1:0] active_cnt,
  output logic [CW-1:0] open_cnt,
  output logic [CW-1:0] rwa_free
);

  localparam logic [CW-1:0] ZONES_W = CW'(NUM_ZONES);

  logic [1:0]    rst_sync;
  logic          rst_n_i;
  logic [CW-1:0] rwa_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_i  = rst_sync[1];
  assign rwa_init = (cfg_rwa_slots == '0) ? ZONES_W : cfg_rwa_slots;

  logic [15:0] adm_status;
  logic        adm_inc_act;
  logic        adm_inc_open;
  logic        adm_take_rwa;
  logic [7:0]  adm_attr;

  zra_admit #(.CW(CW)) u_admit (
    .active_cnt     (active_cnt),
    .open_cnt       (open_cnt),
    .rwa_free       (rwa_free),
    .cfg_max_active (cfg_max_active),
    .cfg_max_open   (cfg_max_open),
    .cfg_rwa_en     (cfg_rwa_en),
    .state          (req_state),
    .attr_in        (req_attr),
    .want_rwa       (req_rwa),
    .wp_aligned     (req_wp_aligned),
    .status         (adm_status),
    .inc_active     (adm_inc_act),
    .inc_open       (adm_inc_open),
    .take_rwa       (adm_take_rwa),
    .attr_out       (adm_attr)
  );

  logic [15:0] rel_status;
  logic        rel_dec_act;
  logic        rel_dec_open;
  logic        rel_give_rwa;
  logic [7:0]  rel_attr;

  zra_release u_release (
    .state      (req_state),
    .attr_in    (req_attr),
    .is_finish  (req_op == OP_FINISH),
    .status     (rel_status),
    .dec_active (rel_dec_act),
    .dec_open   (rel_dec_open),
    .give_rwa   (rel_give_rwa),
    .attr_out   (rel_attr)
  );

  logic        up_act, dn_act, up_open, dn_open, up_rwa, dn_rwa;
  logic [15:0] status_nxt;
  logic [7:0]  attr_nxt;

  always_comb begin
    up_act     = 1'b0;
    dn_act     = 1'b0;
    up_open    = 1'b0;
    dn_open    = 1'b0;
    up_rwa     = 1'b0;
    dn_rwa     = 1'b0;
    status_nxt = ST_OK;
    attr_nxt   = req_attr;
    if (req_valid) begin
      unique case (req_op)
        OP_OPEN: begin
          status_nxt = adm_status;
          attr_nxt   = adm_attr;
          up_act     = adm_inc_act;
          up_open    = adm_inc_open;
          dn_rwa     = adm_take_rwa;
        end
        OP_FINISH, OP_RESET: begin
          status_nxt = rel_status;
          attr_nxt   = rel_attr;
          dn_act     = rel_dec_act;
          dn_open    = rel_dec_open;
          up_rwa     = rel_give_rwa;
        end
        default: begin
          status_nxt = fail_code(ST_BAD_FIELD);
        end
      endcase
    end
  end

  zra_counter #(.CW(CW)) u_cnt_active (
    .clk (clk), .rst_n (rst_n_i), .init_val ('0), .max_val (ZONES_W),
    .up (up_act), .dn (dn_act), .cnt (active_cnt)
  );

  zra_counter #(.CW(CW)) u_cnt_open (
    .clk (clk), .rst_n (rst_n_i), .init_val ('0), .max_val (ZONES_W),
    .up (up_open), .dn (dn_open), .cnt (open_cnt)
  );

  zra_counter #(.CW(CW)) u_cnt_rwa (
    .clk (clk), .rst_n (rst_n_i), .init_val (rwa_init), .max_val (rwa_init),
    .up (up_rwa), .dn (dn_rwa), .cnt (rwa_free)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_attr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= status_nxt;
        rsp_attr   <= attr_nxt;
      end
    end
  end

endmodule

// File: rtl/zra_checker.sv
module zra_checker #(
  parameter int NUM_ZONES = 16,
  parameter int CW        = $clog2(NUM_ZONES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_max_active,
  input logic [CW-1:0] cfg_max_open,
  input logic [CW-1:0] cfg_rwa_slots,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [7:0]    req_attr,
  input logic          rsp_valid,
  input logic [15:0]   rsp_status,
  input logic [7:0]    rsp_attr,
  input logic [CW-1:0] active_cnt,
  input logic [CW-1:0] open_cnt,
  input logic [CW-1:0] rwa_free
);

  logic [CW-1:0] rwa_cap;
  assign rwa_cap = (cfg_rwa_slots == '0) ? CW'(NUM_ZONES) : cfg_rwa_slots;

  // R2: a sampled request is answered on the next edge
  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R4: failures carry the do-not-retry bit
  a_r4_dnr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 16'h0) |-> rsp_status[14]);

  // R4: a rejected request leaves every pool alone
  a_r4_fail_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 16'h0) |->
      ($stable(active_cnt) && $stable(open_cnt) && $stable(rwa_free)));

  // R7: a newly granted RWA consumes exactly one free slot
  a_r7_rwa_take: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 16'h0 && rsp_attr[3] &&
     $past(req_op) == 2'd1 && !$past(req_attr[3])) |->
      (rwa_free == $past(rwa_free) - 1'b1));

  // R11: no pool escapes its bounds
  a_r11_rwa_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rwa_free <= rwa_cap);

  a_r11_active_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_max_active != '0) |-> (active_cnt <= cfg_max_active));

  a_r11_open_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_max_open != '0) |-> (open_cnt <= cfg_max_open));

endmodule

bind zone_admit_ctrl zra_checker #(.NUM_ZONES(NUM_ZONES), .CW(CW)) u_zra_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_max_active (cfg_max_active),
  .cfg_max_open   (cfg_max_open),
  .cfg_rwa_slots  (cfg_rwa_slots),
  .req_valid      (req_valid),
  .req_op         (req_op),
  .req_attr       (req_attr),
  .rsp_valid      (rsp_valid),
  .rsp_status     (rsp_status),
  .rsp_attr       (rsp_attr),
  .active_cnt     (active_cnt),
  .open_cnt       (open_cnt),
  .rwa_free       (rwa_free)
);

// File: tb/tb_zone_admit_ctrl.sv
module tb_zone_admit_ctrl;

  localparam int NZ = 16;
  localparam int CW = $clog2(NZ + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_max_active, cfg_max_open, cfg_rwa_slots;
  logic          cfg_rwa_en;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [2:0]    req_state;
  logic [7:0]    req_attr;
  logic          req_rwa, req_wp_aligned;
  logic          rsp_valid;
  logic [15:0]   rsp_status;
  logic [7:0]    rsp_attr;
  logic [CW-1:0] active_cnt, open_cnt, rwa_free;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  zone_admit_ctrl #(.NUM_ZONES(NZ)) dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_max_active (cfg_max_active), .cfg_max_open (cfg_max_open),
    .cfg_rwa_slots (cfg_rwa_slots), .cfg_rwa_en (cfg_rwa_en),
    .req_valid (req_valid), .req_op (req_op), .req_state (req_state),
    .req_attr (req_attr), .req_rwa (req_rwa), .req_wp_aligned (req_wp_aligned),
    .rsp_valid (rsp_valid), .rsp_status (rsp_status), .rsp_attr (rsp_attr),
    .active_cnt (active_cnt), .open_cnt (open_cnt), .rwa_free (rwa_free)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int a, input int o, input int r);
    chk({req, " active"}, 32'(active_cnt), 32'(a));
    chk({req, " open"}, 32'(open_cnt), 32'(o));
    chk({req, " rwa"}, 32'(rwa_free), 32'(r));
  endtask

  task automatic do_reset(input int ma, input int mo, input int rs, input logic en);
    req_valid = 1'b0; req_op = 2'd0; req_state = 3'd0; req_attr = 8'h0;
    req_rwa = 1'b0; req_wp_aligned = 1'b1;
    cfg_max_active = CW'(ma); cfg_max_open = CW'(mo);
    cfg_rwa_slots = CW'(rs); cfg_rwa_en = en;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [2:0] st, input logic [7:0] attr,
                      input logic rwa, input logic al);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_state = st; req_attr = attr;
    req_rwa = rwa; req_wp_aligned = al;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(3, 2, 2, 1'b1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk_cnt("R1", 0, 0, 2);
    do_reset(0, 0, 0, 1'b1);
    chk_cnt("R1 default pool", 0, 0, NZ);
  endtask

  task automatic t_basic_open;
    do_reset(3, 2, 2, 1'b1);
    send(2'd1, 3'd0, 8'h00, 1'b0, 1'b1);
    chk("R2 valid", 32'(rsp_valid), 1);
    chk("R2 status", 32'(rsp_status), 0);
    chk_cnt("R2 empty open", 1, 1, 2);
    send(2'd1, 3'd0, 8'h00, 1'b0, 1'b1);
    chk_cnt("R2 second open", 2, 2, 2);
    send(2'd1, 3'd0, 8'h00, 1'b0, 1'b1);
    chk("R4 open limit", 32'(rsp_status), 32'h41BE);
    chk_cnt("R4 open limit", 2, 2, 2);
    send(2'd2, 3'd2, 8'h00, 1'b0, 1'b1);
    chk("R8 finish status", 32'(rsp_status), 0);
    chk_cnt("R8 finish open", 1, 1, 2);
    send(2'd1, 3'd1, 8'h00, 1'b0, 1'b1);
    chk("R2 reopen status", 32'(rsp_status), 0);
    chk_cnt("R2 reopen", 1, 1, 2);
    send(2'd3, 3'd3, 8'h00, 1'b0, 1'b1);
    chk_cnt("R8 reset closed", 0, 1, 2);
  endtask

  task automatic t_priority;
    do_reset(1, 1, 1, 1'b1);
    send(2'd1, 3'd0, 8'h00, 1'b0, 1'b1);
    chk_cnt("R2 fill", 1, 1, 1);
    send(2'd1, 3'd0, 8'h00, 1'b1, 1'b1);
    chk("R4 active first", 32'(rsp_status), 32'h41BD);
    chk("R4 attr kept", 32'(rsp_attr), 0);
    send(2'd1, 3'd3, 8'h00, 1'b1, 1'b1);
    chk("R4 open second", 32'(rsp_status), 32'h41BE);
    send(2'd2, 3'd1, 8'h00, 1'b0, 1'b1);
    chk_cnt("R8 finish imp", 0, 0, 1);
    send(2'd1, 3'd0, 8'h00, 1'b1, 1'b1);
    chk("R7 status", 32'(rsp_status), 0);
    chk("R7 attr bit3", 32'(rsp_attr), 32'h08);
    chk_cnt("R7 pools", 1, 1, 0);
    send(2'd1, 3'd1, 8'h00, 1'b1, 1'b1);
    chk("R4 rwa last", 32'(rsp_status), 32'h41B7);
    chk_cnt("R4 rwa last", 1, 1, 0);
    send(2'd3, 3'd2, 8'h08, 1'b0, 1'b1);
    chk("R9 reset attr", 32'(rsp_attr), 32'h08);
    chk_cnt("R9 reset release", 0, 0, 1);
  endtask

  task automatic t_finish_rwa;
    do_reset(0, 0, 1, 1'b1);
    send(2'd1, 3'd0, 8'h80, 1'b1, 1'b1);
    chk("R7 attr keeps others", 32'(rsp_attr), 32'h88);
    send(2'd2, 3'd2, 8'h88, 1'b0, 1'b1);
    chk("R9 finish attr", 32'(rsp_attr), 32'h80);
    chk_cnt("R9 finish release", 0, 0, 1);
    send(2'd2, 3'd3, 8'h08, 1'b0, 1'b1);
    chk("R11 status", 32'(rsp_status), 0);
    chk_cnt("R11 saturate", 0, 0, 1);
    send(2'd2, 3'd5, 8'h00, 1'b0, 1'b1);
    chk("R8 finish full", 32'(rsp_status), 0);
  endtask

  task automatic t_preconditions;
    do_reset(0, 0, 2, 1'b0);
    send(2'd1, 3'd0, 8'h00, 1'b1, 1'b0);
    chk("R5 no capability", 32'(rsp_status), 32'h41B6);
    chk_cnt("R5 unchanged", 0, 0, 2);
    do_reset(0, 0, 2, 1'b1);
    send(2'd1, 3'd0, 8'h00, 1'b1, 1'b0);
    chk("R6 misaligned", 32'(rsp_status), 32'h41B7);
    chk_cnt("R6 unchanged", 0, 0, 2);
    send(2'd1, 3'd5, 8'h00, 1'b0, 1'b1);
    chk("R10 open full", 32'(rsp_status), 32'h41BF);
    send(2'd2, 3'd6, 8'h00, 1'b0, 1'b1);
    chk("R10 finish offline", 32'(rsp_status), 32'h41BF);
    send(2'd1, 3'd2, 8'h08, 1'b1, 1'b1);
    chk("R10 rwa held", 32'(rsp_status), 32'h41B6);
    send(2'd0, 3'd0, 8'h00, 1'b0, 1'b1);
    chk("R10 bad op", 32'(rsp_status), 32'h4002);
    chk_cnt("R10 unchanged", 0, 0, 2);
  endtask

  task automatic t_unlimited;
    do_reset(0, 0, 0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      send(2'd1, 3'd0, 8'h00, 1'b0, 1'b1);
      chk("R3 unlimited", 32'(rsp_status), 0);
    end
    chk_cnt("R3 counts", 5, 5, NZ);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_basic_open();
        t_priority();
        t_finish_rwa();
        t_preconditions();
        t_unlimited();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule